// File: doc/BRIEF.md
# Clocked Serial Byte Transceiver with Prescaled Shift Clock

This block sends and receives one byte at a time over a synchronous serial link. A host writes a byte into the data register. The block shifts that byte out on a data pin and, in the same transfer, samples the data input pin. Once eight bits have moved, the received byte replaces the transmitted one in the data register.

The shift clock comes from one of two sources. It can come from an internal divider running from the system clock, with the ratio chosen by a 3-bit code. It can also come from an external clock pin, which is brought into the system clock domain through a synchronizer. A single control byte sets the following:
- which clock source is used;
- the bit order;
- whether the data and clock pins carry the serial function;
- whether the data output drives both levels or only pulls low;
- whether the active-low ready pin is enabled.

A done flag marks the end of each transfer. The host clears it by reading the data register.

Top module: `csio_unit`

## Requirements
- R1: With the internal clock selected, writing the data register starts a transfer. The shift clock first falls N/2 system cycles after the write edge and then toggles every N/2 cycles. N is 8, 16, 32 or 64 for ratio codes 000 to 011, and 128 or 256 for codes 110 and 111 (control bits [2:0]).
- R2: Ratio codes 100 and 101 behave exactly like code 000, giving divide-by-8.
- R3: The transmitted bit changes on each falling shift clock edge. Control bit 4 = 0 sends bit 0 first and bit 4 = 1 sends bit 7 first.
- R4: The data input is sampled on each rising shift clock edge. After eight bits, reading the data register (address 1) returns the received byte in the order given by control bit 4.
- R5: The shift clock sits high when no transfer is running, and each transfer produces exactly eight falling and eight rising edges.
- R6: When control bit 7 = 1 (open-drain), the data output value is never 1 and the data output enable is asserted only while the bit is 0. When bit 7 = 0 (push-pull), the enable stays asserted while a bit is presented.
- R7: When control bit 5 = 0, neither the data output enable nor the clock output enable is ever asserted.
- R8: The ready output enable follows control bit 6. The ready level goes low on the cycle after a data write that starts a transfer and returns high with the first shift clock edge.
- R9: When control bit 3 = 0, the transfer is clocked by edges of the external clock input after a two-flop synchronizer, and the clock output enable stays deasserted.
- R10: Status bit 0 (address 2) sets after the eighth rising edge and is also driven on `done`. It clears on the cycle after a read of the data register.
- R11: A data register write during a running transfer is ignored. Neither the bits sent nor the received byte change.
- R12: After reset the control and status registers read 0, the shift clock and ready level are high, and no output enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ext_sclk_in | input | 1 | External shift clock pin |
| sdata_in | input | 1 | Serial data input pin |
| sdata_out | output | 1 | Serial data output value |
| sdata_oe | output | 1 | Serial data output enable |
| sclk_out | output | 1 | Internal shift clock output value |
| sclk_oe | output | 1 | Shift clock output enable |
| rdy_n_out | output | 1 | Active-low ready level |
| rdy_oe | output | 1 | Ready pin output enable |
| done | output | 1 | Transfer-complete flag |

## Verification
The bench builds the block with its default parameters: an 8-bit divider counter, which reaches half periods of up to 128 cycles, and a two-stage synchronizer. The divider counter therefore spans every ratio code, including the widest at divide-by-256 and the two reserved codes. The two-stage synchronizer makes the external-clock path show its full latency, which the bench allows for by holding each external clock phase for six cycles. Random control bytes cover all combinations of bit order, drive mode and ready enable.

// File: rtl/csio_pkg.sv
package csio_pkg;

    localparam int BYTE_W = 8;

    // Control byte, bit 7 down to bit 0
    typedef struct packed {
        logic       od;         // 1: open-drain data output
        logic       rdy_en;     // 1: ready pin enabled
        logic       pin_en;     // 1: data/clock pins carry serial function
        logic       msb_first;  // 1: bit 7 first
        logic       int_clk;    // 1: internal divider clock
        logic [2:0] ratio;      // divider code
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;

    // log2 of the half period in system cycles
    function automatic logic [3:0] half_log2(input logic [2:0] code);
        case (code)
            3'b001:  return 4'd3;
            3'b010:  return 4'd4;
            3'b011:  return 4'd5;
            3'b110:  return 4'd6;
            3'b111:  return 4'd7;
            default: return 4'd2;   // 000 and the two reserved codes
        endcase
    endfunction

endpackage

// File: rtl/csio_clkdiv.sv
module csio_clkdiv #(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [3:0] half_lg,
    output logic       sclk,
    output logic       fall_ev,
    output logic       rise_ev
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             tick;
    logic             sclk_q;

    always_comb begin
        limit   = CNT_W'((32'd1 << half_lg) - 32'd1);
        tick    = run && (cnt_q == limit);
        fall_ev = tick && sclk_q;
        rise_ev = tick && !sclk_q;
        sclk    = sclk_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/csio_sync_edge.sv
module csio_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe_q;
    logic            level;
    logic            prev;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= {pipe_q[STAGES-1:0], async_in};
    end

    always_comb begin
        level = pipe_q[STAGES-1];
        prev  = pipe_q[STAGES];
        rise  = level && !prev;
        fall  = !level && prev;
    end
endmodule

// File: rtl/csio_shift_engine.sv
module csio_shift_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] load_val,
    input  logic         msb_first,
    input  logic         fall_ev,
    input  logic         rise_ev,
    input  logic         sin,
    output logic         active,
    output logic         out_bit,
    output logic [W-1:0] shreg,
    output logic         done_pulse,
    output logic         first_edge
);
    localparam int       CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] bitcnt_q;
    logic             active_q;
    logic             out_q;
    logic [W-1:0]     sh_q;

    always_comb begin
        active     = active_q;
        out_bit    = out_q;
        shreg      = sh_q;
        done_pulse = active_q && rise_ev && (bitcnt_q == LAST);
        first_edge = active_q && fall_ev && (bitcnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            out_q    <= 1'b1;
            sh_q     <= '0;
            bitcnt_q <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            sh_q     <= load_val;
            bitcnt_q <= '0;
        end else if (active_q) begin
            if (fall_ev)
                out_q <= msb_first ? sh_q[W-1] : sh_q[0];
            if (rise_ev) begin
                sh_q     <= msb_first ? {sh_q[W-2:0], sin} : {sin, sh_q[W-1:1]};
                bitcnt_q <= bitcnt_q + 1'b1;
                if (bitcnt_q == LAST)
                    active_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/csio_unit.sv
module csio_unit #(
    parameter int DIV_CNT_W   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_sclk_in,
    input  logic       sdata_in,
    output logic       sdata_out,
    output logic       sdata_oe,
    output logic       sclk_out,
    output logic       sclk_oe,
    output logic       rdy_n_out,
    output logic       rdy_oe,
    output logic       done
);
    import csio_pkg::*;

    localparam int DW = $bits(ctrl_t);

    ctrl_t          ctrl_q;
    logic           done_q;
    logic           rdy_n_q;
    logic           wr_ctrl, wr_data, rd_data, start;
    logic           div_sclk, div_fall, div_rise;
    logic           ext_rise, ext_fall;
    logic           fall_ev, rise_ev;
    logic           active, out_bit, done_pulse, first_edge;
    logic [DW-1:0]  shreg;
    reg_addr_e      addr;

    always_comb begin
        addr    = reg_addr_e'(bus_addr);
        wr_ctrl = bus_sel && bus_wr && (addr == REG_CTRL);
        wr_data = bus_sel && bus_wr && (addr == REG_DATA);
        rd_data = bus_sel && bus_rd && (addr == REG_DATA);
        start   = wr_data && !active;
    end

    csio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_sclk_in),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    csio_clkdiv #(.CNT_W(DIV_CNT_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (active && ctrl_q.int_clk),
        .half_lg (half_log2(ctrl_q.ratio)),
        .sclk    (div_sclk),
        .fall_ev (div_fall),
        .rise_ev (div_rise)
    );

    always_comb begin
        fall_ev = ctrl_q.int_clk ? div_fall : ext_fall;
        rise_ev = ctrl_q.int_clk ? div_rise : ext_rise;
    end

    csio_shift_engine #(.W(DW)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .load_val   (bus_wdata),
        .msb_first  (ctrl_q.msb_first),
        .fall_ev    (fall_ev),
        .rise_ev    (rise_ev),
        .sin        (sdata_in),
        .active     (active),
        .out_bit    (out_bit),
        .shreg      (shreg),
        .done_pulse (done_pulse),
        .first_edge (first_edge)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            done_q  <= 1'b0;
            rdy_n_q <= 1'b1;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(bus_wdata);
            if (done_pulse)
                done_q <= 1'b1;
            else if (rd_data)
                done_q <= 1'b0;
            if (start)
                rdy_n_q <= 1'b0;
            else if (first_edge)
                rdy_n_q <= 1'b1;
        end
    end

    always_comb begin
        sclk_out  = ctrl_q.int_clk ? div_sclk : 1'b1;
        sclk_oe   = ctrl_q.pin_en && ctrl_q.int_clk;
        sdata_oe  = ctrl_q.pin_en && (ctrl_q.od ? !out_bit : 1'b1);
        sdata_out = ctrl_q.pin_en && !ctrl_q.od && out_bit;
        rdy_oe    = ctrl_q.rdy_en;
        rdy_n_out = rdy_n_q;
        done      = done_q;
        case (addr)
            REG_CTRL: bus_rdata = ctrl_q;
            REG_DATA: bus_rdata = shreg;
            REG_STAT: bus_rdata = {6'd0, active, done_q};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/csio_unit_chk.sv
module csio_unit_chk (
    input logic clk,
    input logic rst,
    input logic active,
    input logic sclk_out,
    input logic sclk_oe,
    input logic od,
    input logic pin_en,
    input logic sdata_out,
    input logic sdata_oe,
    input logic done,
    input logic rd_data,
    input logic done_pulse,
    input logic start,
    input logic first_edge,
    input logic rdy_n
);
    // R5
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> sclk_out);

    // R6
    od_low_only_chk: assert property (@(posedge clk) disable iff (rst)
        od |-> !sdata_out);

    // R7
    pin_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_en |-> (!sdata_oe && !sclk_oe));

    // R10
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> done);

    // R10
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !done_pulse) |=> !done);

    // R8
    rdy_low_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !rdy_n);

    // R8
    rdy_release_chk: assert property (@(posedge clk) disable iff (rst)
        first_edge |=> rdy_n);
endmodule

bind csio_unit csio_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .sclk_out   (sclk_out),
    .sclk_oe    (sclk_oe),
    .od         (ctrl_q.od),
    .pin_en     (ctrl_q.pin_en),
    .sdata_out  (sdata_out),
    .sdata_oe   (sdata_oe),
    .done       (done),
    .rd_data    (rd_data),
    .done_pulse (done_pulse),
    .start      (start),
    .first_edge (first_edge),
    .rdy_n      (rdy_n_out)
);

// File: tb/csio_unit_tb.sv
module csio_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_sclk_in = 1'b1;
    logic       sdata_in = 1'b0;
    logic       sdata_out, sdata_oe, sclk_out, sclk_oe, rdy_n_out, rdy_oe, done;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csio_unit u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_sclk_in(ext_sclk_in), .sdata_in(sdata_in), .sdata_out(sdata_out),
        .sdata_oe(sdata_oe), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .rdy_n_out(rdy_n_out), .rdy_oe(rdy_oe), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int half_of(input logic [2:0] code);
        case (code)
            3'b001:  return 8;
            3'b010:  return 16;
            3'b011:  return 32;
            3'b110:  return 64;
            3'b111:  return 128;
            default: return 4;
        endcase
    endfunction

    function automatic logic bit_at(input logic [7:0] v, input logic msb, input int j);
        return msb ? v[7-j] : v[j];
    endfunction

    function automatic logic pin_level();
        return sdata_oe ? sdata_out : 1'b1;
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic finish_checks(input logic [7:0] rx, input string tag);
        logic [7:0] v;
        bus_read(2'd2, v);
        chk({"R10 done set ", tag}, int'(v[0]), 1);
        chk({"R10 done pin ", tag}, int'(done), 1);
        bus_read(2'd1, v);
        chk({"R4/R11 rx byte ", tag}, int'(v), int'(rx));
        bus_read(2'd2, v);
        chk({"R10 done cleared ", tag}, int'(v[0]), 0);
    endtask

    task automatic run_int(input logic [7:0] ctrl, input logic [7:0] tx,
                           input logic [7:0] rx, input bit poke, input string tag);
        int h, c, edges, last_t, extra;
        bit timing_ok, od_ok, pp_ok, oe_seen;
        logic [7:0] got, exp_seq;
        logic prev_s;
        h = half_of(ctrl[2:0]);
        timing_ok = 1; od_ok = 1; pp_ok = 1; oe_seen = 0;
        got = '0; edges = 0; c = 0; last_t = 0; prev_s = 1'b1;
        for (int j = 0; j < 8; j++) exp_seq[j] = bit_at(tx, ctrl[4], j);
        bus_write(2'd0, ctrl);
        bus_write(2'd1, tx);
        chk({"R8 ready enable ", tag}, int'(rdy_oe), int'(ctrl[6]));
        while (edges < 16 && c < 20 * h) begin
            @(negedge clk);
            c++;
            if (c == 1) chk({"R8 ready low ", tag}, int'(rdy_n_out), 0);
            if (poke && c == h + 2) begin
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = ~tx;
            end
            if (poke && c == h + 3) begin
                bus_sel = 1'b0; bus_wr = 1'b0;
            end
            if (sdata_oe || sclk_oe) oe_seen = 1;
            if (ctrl[7] && sdata_out) od_ok = 0;
            if (sclk_out != prev_s) begin
                edges++;
                if (c - last_t != h) timing_ok = 0;
                last_t = c;
                if (!sclk_out) begin
                    sdata_in = bit_at(rx, ctrl[4], (edges - 1) / 2);
                    if (edges == 1) chk({"R8 ready released ", tag}, int'(rdy_n_out), 1);
                end else begin
                    got[edges/2 - 1] = pin_level();
                    if (!ctrl[7] && ctrl[5] && !sdata_oe) pp_ok = 0;
                end
            end
            prev_s = sclk_out;
        end
        extra = 0;
        repeat (2 * h) begin
            @(negedge clk);
            if (sclk_out != 1'b1) extra++;
        end
        chk({"R5 edge count ", tag}, edges, 16);
        chk({"R5 idle high ", tag}, extra, 0);
        chk({"R1/R2 half period ", tag}, int'(timing_ok), 1);
        if (ctrl[5]) begin
            chk({"R3 tx order ", tag}, int'(got), int'(exp_seq));
            chk({"R6 drive mode ", tag}, int'(od_ok && pp_ok), 1);
        end else begin
            chk({"R7 no output enable ", tag}, int'(oe_seen), 0);
        end
        finish_checks(rx, tag);
    endtask

    task automatic run_ext(input logic [7:0] ctrl, input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] got, exp_seq;
        bit clk_oe_seen;
        for (int j = 0; j < 8; j++) exp_seq[j] = bit_at(tx, ctrl[4], j);
        clk_oe_seen = 0;
        bus_write(2'd0, ctrl);
        bus_write(2'd1, tx);
        @(negedge clk);
        chk("R8 ready low ext", int'(rdy_n_out), 0);
        for (int j = 0; j < 8; j++) begin
            ext_sclk_in = 1'b0;
            sdata_in = bit_at(rx, ctrl[4], j);
            repeat (6) begin
                @(negedge clk);
                if (sclk_oe) clk_oe_seen = 1;
            end
            if (j == 0) chk("R8 ready released ext", int'(rdy_n_out), 1);
            got[j] = pin_level();
            ext_sclk_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R9 clock enable off ext", int'(clk_oe_seen), 0);
        chk("R9 tx order ext", int'(got), int'(exp_seq));
        finish_checks(rx, "ext");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        bus_read(2'd0, v);
        chk("R12 ctrl reset", int'(v), 0);
        bus_read(2'd2, v);
        chk("R12 status reset", int'(v), 0);
        chk("R12 ready high", int'(rdy_n_out), 1);
        chk("R12 sclk high", int'(sclk_out), 1);
        chk("R12 no enables", int'({sdata_oe, sclk_oe, rdy_oe}), 0);

        // directed corners
        run_int(8'b0110_1111, 8'hC3, 8'h5A, 1'b0, "R1 div256");
        run_int(8'b0010_1100, 8'h81, 8'h7E, 1'b0, "R2 code100");
        run_int(8'b1011_1101, 8'h3C, 8'hE1, 1'b0, "R2 code101 od");
        run_int(8'b0010_1000, 8'h96, 8'h2D, 1'b1, "R11 busy write");
        run_int(8'b0000_1001, 8'hF0, 8'h0F, 1'b0, "R7 pins off");
        run_ext(8'b0111_0000, 8'hA7, 8'h4B);
        run_ext(8'b1010_0000, 8'h19, 8'hD2);

        // random transfers
        for (int i = 0; i < 10; i++) begin
            logic [7:0] c, t, r;
            logic [2:0] code;
            code = 3'($urandom_range(0, 7));
            if (code == 3'b111 || code == 3'b110) code = 3'($urandom_range(0, 3));
            c = {1'($urandom), 1'($urandom), 1'b1, 1'($urandom), 1'b1, code};
            t = 8'($urandom);
            r = 8'($urandom);
            run_int(c, t, r, 1'b0, "R3 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule